// File: doc/BRIEF.md
# Byte-Wide Flash Command Front End with Boot Sector Lockout

This block is the command-register front end of a byte-wide NOR-style flash device. It watches the asynchronous chip-enable, output-enable and write-enable strobes through a synchronizer clocked by the system clock. Each write cycle delivers one address and one data byte. The block recognises multi-cycle unlock-and-command sequences and runs byte-program and whole-chip-erase operations, each timed internally. While an operation runs, a read returns a data-polling pattern instead of the stored byte.

A one-time lockout can protect a 16 KB boot sector. Once the lockout is set, programs aimed at that sector are dropped, and chip erase leaves the sector untouched. The storage is a small register array. Each of the two regions (the boot sector and the main array) holds 2^MEM_AW bytes, selected by the low address bits. Upper address bits alias within a region.

All pins are plain bus strobes and buses. There is no valid/ready handshake and no back-pressure. A write that arrives while the block is busy is dropped silently. The host learns that an operation has finished by data polling or by watching `busy`.

Top module: `flash_cmd_front`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1 were sampled, delayed by the SYNC_N synchronizer stages plus one register. While `dq_oe` is 0 (high impedance), `dq_out` is 0x00. While it is 1, `dq_out` carries the read value for `addr`.
- R2: After reset, every cell reads 0xFF, `busy` is 0 and the lockout is clear.
- R3: A completed program leaves the cell at old AND written. Bits only go from 1 to 0. The cell index is {boot-sector hit, addr[MEM_AW-1:0]}.
- R4: A write cycle is the window in which `ce_n` and `we_n` are both low. The address is taken when the window opens, which is the later of the two falling edges. The data is taken when the window closes, which is the earlier of the two rising edges. Writes controlled by `we_n` and writes controlled by `ce_n` both work.
- R5: Program takes four writes: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (target, data).
- R6: Chip erase takes six writes: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x10). When it completes, every cell outside a locked boot sector is 0xFF.
- R7: The same six writes with 0x40 as the last byte set the lockout. No command clears it. Once it is set, a program aimed at the boot sector is dropped: the cell keeps its value and `busy` stays 0. With BOOT_TOP=1, the boot sector is every address whose top ADDR_W-14 bits are all ones (0x7C000 to 0x7FFFF). With BOOT_TOP=0, it is every address whose top bits are all zeros.
- R8: A chip erase with the lockout set leaves boot-sector contents unchanged and still erases the main region.
- R9: Any write that does not match the next expected step returns the decoder to idle. It changes no cell and starts no operation.
- R10: `busy` is high for exactly PROG_CYC clock cycles after a program and ERASE_CYC cycles after an erase. Writes made while `busy` is high are ignored, including their effect on the sequence decoder.
- R11: While a program is running, a read returns {~data[7], 7'b0}, where data is the byte being programmed. While an erase is running, a read returns 0x00. Once the operation completes, a read returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 0x00 while not driven |
| dq_oe | output | 1 | High when the data bus would be driven |
| busy | output | 1 | Internal program or erase in progress |

## Verification
The bench programs every cell of both regions twice and reads each one back. It checks the AND result of the two passes, so a design that overwrote cells instead of clearing bits would fail on most cells. Half of the second pass uses writes controlled by `ce_n`, and in every write cycle the bench scrambles the address after the window opens and sets the correct data only just before it closes. A design that latched on the wrong edge would program the wrong cell or the wrong byte. Further corner cases are broken sequences, a write made during an erase that would otherwise begin an unlock, polling reads while busy, and programs and erases under lockout. A design that gets these wrong shows a stray busy pulse, a changed cell, or a boot sector left erased.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PROG_ARM,
    SQ_ERASE_SET,
    SQ_EKEY1,
    SQ_EKEY2
  } seq_state_t;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_PROG,
    EN_ERASE
  } eng_state_t;

  localparam int unsigned UNLOCK_ADDR_A = 'h5555;
  localparam int unsigned UNLOCK_ADDR_B = 'h2AAA;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ESETUP  = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_LOCK    = 8'h40;

endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              rd_en,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  // strobe chain: bit 2 = ce, bit 1 = oe, bit 0 = we
  logic [2:0] sh [SYNC_N];
  logic [2:0] s;
  logic       wr_lvl;
  logic       wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sh[i] <= 3'b111;
    end else begin
      sh[0] <= {ce_n, oe_n, we_n};
      for (int i = 1; i < SYNC_N; i++) sh[i] <= sh[i-1];
    end
  end

  assign s      = sh[SYNC_N-1];
  assign wr_lvl = ~s[2] & ~s[0];
  assign rd_en  = ~s[2] & ~s[1] & s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= 8'h00;
    end else begin
      wr_prev <= wr_lvl;
      wr_evt  <= wr_prev & ~wr_lvl;
      // window opens at the later falling strobe: take the address
      if (wr_lvl && !wr_prev) wr_addr <= addr;
      // window closes at the earlier rising strobe: take the data
      if (wr_prev && !wr_lvl) wr_data <= din;
    end
  end

  // R4: one write event per closed window
  a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              prog_go,
  output logic              erase_go,
  output logic              lock_go
);

  seq_state_t state, nxt;
  logic       evt, at_a, at_b;

  assign evt  = wr_evt & ~busy;
  assign at_a = (wr_addr == ADDR_W'(UNLOCK_ADDR_A));
  assign at_b = (wr_addr == ADDR_W'(UNLOCK_ADDR_B));

  always_comb begin
    nxt      = state;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    lock_go  = 1'b0;
    if (evt) begin
      nxt = SQ_IDLE;
      unique case (state)
        SQ_IDLE:      if (at_a && wr_data == KEY_FIRST)  nxt = SQ_KEY1;
        SQ_KEY1:      if (at_b && wr_data == KEY_SECOND) nxt = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a && wr_data == CMD_PROGRAM)     nxt = SQ_PROG_ARM;
          else if (at_a && wr_data == CMD_ESETUP) nxt = SQ_ERASE_SET;
        end
        SQ_PROG_ARM:  prog_go = 1'b1;
        SQ_ERASE_SET: if (at_a && wr_data == KEY_FIRST)  nxt = SQ_EKEY1;
        SQ_EKEY1:     if (at_b && wr_data == KEY_SECOND) nxt = SQ_EKEY2;
        SQ_EKEY2: begin
          erase_go = at_a && (wr_data == CMD_CHIP);
          lock_go  = at_a && (wr_data == CMD_LOCK);
        end
        default:      nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  // R10: a write made while busy leaves the decoder where it was
  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_evt) |=> (state == $past(state)));

  // R9: at most one operation launched per write
  a_r9_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, erase_go, lock_go}));

endmodule

// File: rtl/flash_array_engine.sv
module flash_array_engine
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned MEM_AW    = 4,
  parameter int unsigned BOOT_TOP  = 1,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic              lock_go,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic [7:0]        rd_data
);

  localparam int unsigned SEC_BITS = 14;
  localparam int unsigned IDX_W    = MEM_AW + 1;
  localparam int unsigned CELLS    = 1 << IDX_W;
  localparam int unsigned HALF     = 1 << MEM_AW;
  localparam int unsigned TW       = $clog2(ERASE_CYC + 1);

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    if (BOOT_TOP != 0) return &a[ADDR_W-1:SEC_BITS];
    else               return ~|a[ADDR_W-1:SEC_BITS];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return {in_boot(a), a[MEM_AW-1:0]};
  endfunction

  eng_state_t       st;
  logic [TW-1:0]    timer;
  logic [IDX_W-1:0] p_idx;
  logic [7:0]       p_data;
  logic             lock_q;
  logic             finish;
  logic [7:0]       cells [CELLS];

  assign finish = (st != EN_IDLE) && (timer == '0);
  assign busy   = (st != EN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EN_IDLE;
      timer  <= '0;
      p_idx  <= '0;
      p_data <= 8'hFF;
      lock_q <= 1'b0;
    end else begin
      if (lock_go) lock_q <= 1'b1;
      unique case (st)
        EN_IDLE: begin
          if (prog_go && !(lock_q && in_boot(op_addr))) begin
            st     <= EN_PROG;
            timer  <= TW'(PROG_CYC - 1);
            p_idx  <= idx_of(op_addr);
            p_data <= op_data;
          end else if (erase_go) begin
            st    <= EN_ERASE;
            timer <= TW'(ERASE_CYC - 1);
          end
        end
        default: begin
          if (timer == '0) st <= EN_IDLE;
          else             timer <= timer - 1'b1;
        end
      endcase
    end
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    localparam bit IN_BOOT_HALF = (g >= HALF);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 8'hFF;
      end else if (finish) begin
        if (st == EN_PROG && p_idx == IDX_W'(g))
          q <= q & p_data;
        else if (st == EN_ERASE && !(IN_BOOT_HALF && lock_q))
          q <= 8'hFF;
      end
    end
    assign cells[g] = q;
  end

  always_comb begin
    unique case (st)
      EN_PROG:  rd_data = {~p_data[7], 7'b0};
      EN_ERASE: rd_data = 8'h00;
      default:  rd_data = cells[idx_of(rd_addr)];
    endcase
  end

  // R3: programming never sets a bit
  a_r3_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && st == EN_PROG) |=>
      ((cells[$past(p_idx)] & ~$past(cells[p_idx])) == 8'h00));

  // R7: the lockout never clears
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R7: a locked boot-sector program starts nothing
  a_r7_locked_prog_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_IDLE && prog_go && !erase_go && lock_q && in_boot(op_addr)) |=>
      (st == EN_IDLE));

  // R8: erase under lockout keeps the first boot cell
  a_r8_boot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && st == EN_ERASE && lock_q) |=> (cells[HALF] == $past(cells[HALF])));

  // R10: the operation timer stays inside the longest window
  a_r10_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (timer < TW'(ERASE_CYC)));

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned MEM_AW    = 4,
  parameter int unsigned BOOT_TOP  = 1,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 40,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              busy
);

  logic              rd_en, wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data, rd_data;
  logic              prog_go, erase_go, lock_go;

  flash_bus_sampler #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_sampler (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din(dq_in),
    .rd_en, .wr_evt, .wr_addr, .wr_data
  );

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .busy, .wr_evt, .wr_addr, .wr_data,
    .prog_go, .erase_go, .lock_go
  );

  flash_array_engine #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .BOOT_TOP(BOOT_TOP),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_engine (
    .clk, .rst_n, .prog_go, .erase_go, .lock_go,
    .op_addr(wr_addr), .op_data(wr_data), .rd_addr(addr),
    .busy, .rd_data
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= 8'h00;
    end else begin
      dq_oe  <= rd_en;
      dq_out <= rd_en ? rd_data : 8'h00;
    end
  end

  // R1: nothing on the data bus while it is released
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == 8'h00));

endmodule

// File: tb/flash_cmd_front_bench.sv
module flash_cmd_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int PROG_CYC = 16;
  localparam int ERASE_CYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out;
  logic dq_oe, busy;

  int checks = 0;
  int fails = 0;
  int busy_rises = 0;
  int run_len = 0;
  int last_run = 0;
  logic busy_d = 1'b0;
  logic [7:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_front #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_flash_cmd_front (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .dq_in, .dq_out, .dq_oe, .busy
  );

  always @(negedge clk) begin
    if (busy && !busy_d) busy_rises <= busy_rises + 1;
    if (busy) run_len <= run_len + 1;
    else if (busy_d) begin
      last_run <= run_len;
      run_len  <= 0;
    end
    busy_d <= busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cidx(input logic [AW-1:0] a);
    return ((a[18:14] == 5'h1F) ? 16 : 0) + int'(a[3:0]);
  endfunction

  function automatic logic [AW-1:0] cell_addr(input int i);
    return (i >= 16) ? (19'h7C000 + AW'(i - 16)) : (19'h01230 + AW'(i));
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit ce_ctrl);
    addr  = a;
    dq_in = ~d;
    if (ce_ctrl) begin we_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
    else         begin ce_n = 1'b0; @(negedge clk); we_n = 1'b0; end
    repeat (4) @(negedge clk);
    addr  = a ^ 19'h00003;
    dq_in = d;
    repeat (2) @(negedge clk);
    if (ce_ctrl) begin ce_n = 1'b1; @(negedge clk); we_n = 1'b1; end
    else         begin we_n = 1'b1; @(negedge clk); ce_n = 1'b1; end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    addr = a;
    ce_n = 1'b0;
    oe_n = 1'b0;
    repeat (6) @(negedge clk);
    d  = dq_out;
    oe = dq_oe;
    oe_n = 1'b1;
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic prog_start(input logic [AW-1:0] a, input logic [7:0] d, input bit ce_ctrl);
    wr(19'h05555, 8'hAA, 1'b0);
    wr(19'h02AAA, 8'h55, 1'b0);
    wr(19'h05555, 8'hA0, 1'b0);
    wr(a, d, ce_ctrl);
  endtask

  task automatic six_start(input logic [7:0] last);
    wr(19'h05555, 8'hAA, 1'b0);
    wr(19'h02AAA, 8'h55, 1'b0);
    wr(19'h05555, 8'h80, 1'b0);
    wr(19'h05555, 8'hAA, 1'b0);
    wr(19'h02AAA, 8'h55, 1'b0);
    wr(19'h05555, last, 1'b0);
  endtask

  task automatic read_all(input string req);
    logic [7:0] d;
    logic oe;
    for (int i = 0; i < 32; i++) begin
      rd(cell_addr(i), d, oe);
      chk(oe === 1'b1 && d === model[i], req, int'(d), int'(model[i]));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    logic oe;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    chk(busy === 1'b0, "R2 busy", int'(busy), 0);
    for (int i = 0; i < 32; i++) model[i] = 8'hFF;
    read_all("R2 erased");

    // R1 released bus
    addr = cell_addr(0);
    ce_n = 1'b0; oe_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dq_oe === 1'b0 && dq_out === 8'h00, "R1 oe high", int'(dq_oe), 0);
    ce_n = 1'b1; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(dq_oe === 1'b0 && dq_out === 8'h00, "R1 ce high", int'(dq_oe), 0);
    oe_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 / R3 first pass over every cell
    for (int i = 0; i < 32; i++) begin
      logic [7:0] p;
      p = 8'((i * 29 + 7) ^ (i >= 16 ? 8'h5A : 8'h00));
      prog_start(cell_addr(i), p, 1'b0);
      wait_idle();
      model[i] = model[i] & p;
      if (i == 0) chk(last_run == PROG_CYC, "R10 program length", last_run, PROG_CYC);
    end
    read_all("R5 program");

    // R3 / R4 second pass, odd cells by ce_n-controlled writes
    for (int i = 0; i < 32; i++) begin
      logic [7:0] p;
      p = 8'(i * 53 + 8'h3C);
      prog_start(cell_addr(i), p, (i % 2) == 1);
      wait_idle();
      model[i] = model[i] & p;
    end
    read_all("R3 R4 and-program");

    // R11 polling during program
    prog_start(cell_addr(0), 8'h00, 1'b0);
    rd(cell_addr(0), d, oe);
    chk(busy === 1'b1 && d === 8'h80, "R11 program poll", int'(d), 'h80);
    wait_idle();
    model[0] = 8'h00;
    rd(cell_addr(0), d, oe);
    chk(d === 8'h00, "R11 after program", int'(d), 0);

    // R6 erase with polling
    six_start(8'h10);
    rd(cell_addr(5), d, oe);
    chk(busy === 1'b1 && d === 8'h00, "R11 erase poll", int'(d), 0);
    wait_idle();
    chk(last_run == ERASE_CYC, "R10 erase length", last_run, ERASE_CYC);
    for (int i = 0; i < 32; i++) model[i] = 8'hFF;
    read_all("R6 erase");

    // R9 broken sequences
    r0 = busy_rises;
    wr(19'h05555, 8'hAA, 1'b0);
    wr(19'h02AAA, 8'h33, 1'b0);
    wr(19'h05555, 8'hA0, 1'b0);
    wr(cell_addr(1), 8'h00, 1'b0);
    wr(19'h05555, 8'hAA, 1'b0);
    wr(19'h01234, 8'h55, 1'b0);
    wr(19'h05555, 8'hA0, 1'b0);
    wr(cell_addr(1), 8'h00, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy_rises == r0, "R9 no operation", busy_rises - r0, 0);
    rd(cell_addr(1), d, oe);
    chk(d === 8'hFF, "R9 cell unchanged", int'(d), 'hFF);
    prog_start(cell_addr(1), 8'h0F, 1'b0);
    wait_idle();
    model[1] = 8'h0F;
    rd(cell_addr(1), d, oe);
    chk(d === 8'h0F, "R9 recovery", int'(d), 'h0F);

    // R10 write during erase is ignored
    six_start(8'h10);
    wr(19'h05555, 8'hAA, 1'b0);
    wait_idle();
    for (int i = 0; i < 32; i++) model[i] = 8'hFF;
    r0 = busy_rises;
    wr(19'h02AAA, 8'h55, 1'b0);
    wr(19'h05555, 8'hA0, 1'b0);
    wr(cell_addr(2), 8'h00, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy_rises == r0, "R10 busy write dropped", busy_rises - r0, 0);
    rd(cell_addr(2), d, oe);
    chk(d === 8'hFF, "R10 cell unchanged", int'(d), 'hFF);

    // R7 lockout
    prog_start(cell_addr(20), 8'h5A, 1'b0); wait_idle(); model[20] = 8'h5A;
    prog_start(cell_addr(5), 8'hA5, 1'b0);  wait_idle(); model[5]  = 8'hA5;
    r0 = busy_rises;
    six_start(8'h40);
    repeat (20) @(negedge clk);
    chk(busy_rises == r0, "R7 lock no busy", busy_rises - r0, 0);
    prog_start(cell_addr(20), 8'h00, 1'b0);
    repeat (30) @(negedge clk);
    chk(busy_rises == r0, "R7 boot program dropped", busy_rises - r0, 0);
    rd(cell_addr(20), d, oe);
    chk(d === 8'h5A, "R7 boot cell kept", int'(d), 'h5A);
    prog_start(cell_addr(6), 8'h12, 1'b0); wait_idle(); model[6] = 8'h12;
    rd(cell_addr(6), d, oe);
    chk(d === 8'h12, "R7 main still programmable", int'(d), 'h12);

    // R8 erase under lockout
    six_start(8'h10);
    wait_idle();
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
    read_all("R8 locked erase");
    six_start(8'h10);
    wait_idle();
    rd(cell_addr(20), d, oe);
    chk(d === 8'h5A, "R7 lock permanent", int'(d), 'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule